// File: doc/BRIEF.md
# Event Framing Stage with Burst Summary

This block sits between a detector readout path and a memory writer. For each accepted trigger it emits two header words, passes the detector payload through unchanged, and closes the event with two trailer words. The header words carry the event's sequence number, the burst it belongs to, and the trigger time. The trailer words carry a fixed marker, the payload length and the errors seen during the event. All output words are 32 bits wide. Output goes out over a valid/ready handshake, and any stall from the writer is passed back to the payload source.

Beam bursts are marked by start and end pulses. At the start of a burst, the burst number advances and event numbering begins again at zero. When a burst ends, any event still in flight is completed first. The block then emits a two-word summary: the number of event words written during the burst, and the readout time. The readout time is the number of cycles the last event kept the block busy after the burst ended.

Top module: `evt_formatter`

## Requirements
- R1: After synchronous reset, out_valid and in_ready are low and no word is emitted until a burst is open and a trigger arrives.
- R2: The first header word holds the event number in bits 31:16, the burst number in bits 15:8 and zero in bits 7:0. The second header word is the trig_time value captured when the trigger was accepted.
- R3: Payload words follow the two header words unchanged and in arrival order. The word marked in_last is the final payload word of the event.
- R4: The first trailer word is the constant 0xFEEDFACE. The second trailer word holds the number of payload words in bits 23:0 and the accumulated error flags in bits 31:24.
- R5: The burst number starts at zero after reset and goes up by one on each burst_start, so the first burst is numbered 1. Within a burst, events are numbered 0, 1, 2 and so on.
- R6: A trigger is accepted only when a burst is open and no event or summary is in progress. Any other trigger is ignored and produces no words.
- R7: err_in is OR-accumulated on every cycle from the trigger's acceptance until the second trailer word is presented. The accumulated value is cleared once that word is accepted, so the next event starts with zero.
- R8: After burst_end, once no event is in progress, two summary words are emitted. The first is the count of event words (headers, payload and trailers) accepted since burst_start. The second is the readout time.
- R9: The readout time equals the number of clock edges after the burst_end edge, up to and including the edge that accepts the last event's second trailer word. It is zero when no event is in progress at burst_end.
- R10: While out_ready is low, no word is dropped or duplicated, and a presented framing or summary word stays valid and unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | One-cycle pulse opening a burst |
| burst_end | input | 1 | One-cycle pulse closing a burst |
| trig | input | 1 | One-cycle trigger pulse |
| trig_time | input | 32 | Time of arrival sampled with trig |
| err_in | input | 8 | Error flags, accumulated per event |
| in_valid | input | 1 | Payload word valid |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Marks the final payload word |
| in_ready | output | 1 | Payload word accepted when high with in_valid |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Memory writer can accept |

## Verification
Most internal faults show up at the ports within one event. A stale event or burst counter gives a wrong header on the next trigger. A payload counter that is off gives a wrong length in the trailer a few cycles after in_last. An error register that is not cleared carries flags into the following event's trailer. Faults in the word total or the readout timer only show in the summary words after burst_end, so the bench ends a burst in the middle of an event while the writer stalls, and compares the timer against edge counts taken at the ports.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    localparam int WORD_W = 32;
    localparam int EVT_W  = 16;
    localparam int BST_W  = 8;
    localparam int ERR_W  = 8;
    localparam int RSV_W  = WORD_W - EVT_W - BST_W;
    localparam int CNT_W  = WORD_W - ERR_W;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR1, S_HDR2, S_PAY, S_TRL1, S_TRL2, S_SUM1, S_SUM2
    } fst_t;

    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [BST_W-1:0] bst;
        logic [RSV_W-1:0] rsv;
    } hdr_t;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [CNT_W-1:0] cnt;
    } trl_t;

    function automatic hdr_t pack_hdr(logic [EVT_W-1:0] e, logic [BST_W-1:0] b);
        hdr_t h;
        h.evt = e;
        h.bst = b;
        h.rsv = '0;
        return h;
    endfunction

    function automatic trl_t pack_trl(logic [ERR_W-1:0] e, logic [CNT_W-1:0] c);
        trl_t t;
        t.err = e;
        t.cnt = c;
        return t;
    endfunction

    function automatic logic in_event(fst_t s);
        return (s == S_HDR1) || (s == S_HDR2) || (s == S_PAY) ||
               (s == S_TRL1) || (s == S_TRL2);
    endfunction
endpackage

// File: rtl/fmt_counters.sv
module fmt_counters
    import fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                burst_start,
    input  logic                burst_end,
    input  logic                word_acc,
    input  logic                pay_acc,
    input  logic                evt_done,
    input  logic                sum_done,
    input  logic                busy,
    input  logic                err_en,
    input  logic [ERR_W-1:0]    err_in,
    output logic                burst_act,
    output logic                sum_pend,
    output logic [EVT_W-1:0]    evt_cnt,
    output logic [BST_W-1:0]    bst_cnt,
    output logic [CNT_W-1:0]    pay_cnt,
    output logic [ERR_W-1:0]    err_acc,
    output logic [WORD_W-1:0]   tot_cnt,
    output logic [WORD_W-1:0]   rt_cnt
);
    // burst window and summary request
    always_ff @(posedge clk) begin
        if (rst) begin
            burst_act <= 1'b0;
            sum_pend  <= 1'b0;
        end else begin
            if (burst_start)    burst_act <= 1'b1;
            else if (burst_end) burst_act <= 1'b0;
            if (burst_end)      sum_pend  <= 1'b1;
            else if (sum_done)  sum_pend  <= 1'b0;
        end
    end

    // event and burst numbering
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_cnt <= '0;
            bst_cnt <= '0;
        end else if (burst_start) begin
            evt_cnt <= '0;
            bst_cnt <= bst_cnt + 1'b1;
        end else if (evt_done) begin
            evt_cnt <= evt_cnt + 1'b1;
        end
    end

    // per-event payload length and error flags
    always_ff @(posedge clk) begin
        if (rst) begin
            pay_cnt <= '0;
            err_acc <= '0;
        end else begin
            if (evt_done)     pay_cnt <= '0;
            else if (pay_acc) pay_cnt <= pay_cnt + 1'b1;
            if (evt_done)     err_acc <= '0;
            else if (err_en)  err_acc <= err_acc | err_in;
        end
    end

    // per-burst totals
    always_ff @(posedge clk) begin
        if (rst) begin
            tot_cnt <= '0;
            rt_cnt  <= '0;
        end else begin
            if (burst_start)   tot_cnt <= '0;
            else if (word_acc) tot_cnt <= tot_cnt + 1'b1;
            if (burst_end)             rt_cnt <= '0;
            else if (sum_pend && busy) rt_cnt <= rt_cnt + 1'b1;
        end
    end

    AST_PAY_NONZERO: assert property (@(posedge clk) disable iff (rst)
        evt_done |-> (pay_cnt != '0)); // R4
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        evt_done |=> (err_acc == '0)); // R7
    AST_RT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (sum_pend && !busy && !burst_end) |=> $stable(rt_cnt)); // R9
endmodule

// File: rtl/fmt_seq.sv
module fmt_seq
    import fmt_pkg::*;
#(
    parameter logic [WORD_W-1:0] MARKER = 32'hFEED_FACE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig,
    input  logic [WORD_W-1:0]   trig_time,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                in_last,
    input  logic                out_ready,
    input  logic                burst_act,
    input  logic                sum_pend,
    input  logic [EVT_W-1:0]    evt_cnt,
    input  logic [BST_W-1:0]    bst_cnt,
    input  logic [CNT_W-1:0]    pay_cnt,
    input  logic [ERR_W-1:0]    err_acc,
    input  logic [WORD_W-1:0]   tot_cnt,
    input  logic [WORD_W-1:0]   rt_cnt,
    output logic                in_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic                word_acc,
    output logic                pay_acc,
    output logic                evt_done,
    output logic                sum_done,
    output logic                busy,
    output logic                err_en
);
    fst_t              state, nxt;
    hdr_t              hdr_q;
    logic [WORD_W-1:0] ts_q;
    logic              fire;

    assign in_ready = (state == S_PAY) && out_ready;
    assign pay_acc  = in_valid && in_ready;
    assign fire     = out_valid && out_ready;
    assign busy     = in_event(state);
    assign err_en   = busy && (state != S_TRL2);
    assign word_acc = fire && busy;
    assign evt_done = fire && (state == S_TRL2);
    assign sum_done = fire && (state == S_SUM2);

    always_comb begin
        out_valid = 1'b1;
        out_data  = '0;
        unique case (state)
            S_IDLE: out_valid = 1'b0;
            S_HDR1: out_data  = hdr_q;
            S_HDR2: out_data  = ts_q;
            S_PAY: begin
                out_valid = in_valid;
                out_data  = in_data;
            end
            S_TRL1: out_data  = MARKER;
            S_TRL2: out_data  = pack_trl(err_acc, pay_cnt);
            S_SUM1: out_data  = tot_cnt;
            S_SUM2: out_data  = rt_cnt;
            default: out_valid = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (sum_pend)              nxt = S_SUM1;
                else if (trig && burst_act) nxt = S_HDR1;
            end
            S_HDR1: if (fire) nxt = S_HDR2;
            S_HDR2: if (fire) nxt = S_PAY;
            S_PAY:  if (pay_acc && in_last) nxt = S_TRL1;
            S_TRL1: if (fire) nxt = S_TRL2;
            S_TRL2: if (fire) nxt = S_IDLE;
            S_SUM1: if (fire) nxt = S_SUM2;
            S_SUM2: if (fire) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            hdr_q <= '0;
            ts_q  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && nxt == S_HDR1) begin
                hdr_q <= pack_hdr(evt_cnt, bst_cnt);
                ts_q  <= trig_time;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && state != S_PAY) |=> (out_valid && $stable(out_data))); // R10
    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == S_IDLE && state == S_HDR1) |-> $past(burst_act)); // R6
    AST_SUM_REQ: assert property (@(posedge clk) disable iff (rst)
        (state == S_SUM1 || state == S_SUM2) |-> sum_pend); // R8
endmodule

// File: rtl/evt_formatter.sv
module evt_formatter
    import fmt_pkg::*;
#(
    parameter logic [WORD_W-1:0] MARKER = 32'hFEED_FACE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                burst_start,
    input  logic                burst_end,
    input  logic                trig,
    input  logic [WORD_W-1:0]   trig_time,
    input  logic [ERR_W-1:0]    err_in,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                in_last,
    output logic                in_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    input  logic                out_ready
);
    logic              burst_act, sum_pend;
    logic [EVT_W-1:0]  evt_cnt;
    logic [BST_W-1:0]  bst_cnt;
    logic [CNT_W-1:0]  pay_cnt;
    logic [ERR_W-1:0]  err_acc;
    logic [WORD_W-1:0] tot_cnt, rt_cnt;
    logic              word_acc, pay_acc, evt_done, sum_done, busy, err_en;

    fmt_counters u_cnt (
        .clk(clk), .rst(rst),
        .burst_start(burst_start), .burst_end(burst_end),
        .word_acc(word_acc), .pay_acc(pay_acc), .evt_done(evt_done),
        .sum_done(sum_done), .busy(busy), .err_en(err_en), .err_in(err_in),
        .burst_act(burst_act), .sum_pend(sum_pend),
        .evt_cnt(evt_cnt), .bst_cnt(bst_cnt), .pay_cnt(pay_cnt),
        .err_acc(err_acc), .tot_cnt(tot_cnt), .rt_cnt(rt_cnt)
    );

    fmt_seq #(.MARKER(MARKER)) u_seq (
        .clk(clk), .rst(rst),
        .trig(trig), .trig_time(trig_time),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .out_ready(out_ready),
        .burst_act(burst_act), .sum_pend(sum_pend),
        .evt_cnt(evt_cnt), .bst_cnt(bst_cnt), .pay_cnt(pay_cnt),
        .err_acc(err_acc), .tot_cnt(tot_cnt), .rt_cnt(rt_cnt),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .word_acc(word_acc), .pay_acc(pay_acc), .evt_done(evt_done),
        .sum_done(sum_done), .busy(busy), .err_en(err_en)
    );

    AST_HDR_NEEDS_BURST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(burst_act)); // R6
endmodule

// File: tb/sim_evt_formatter.sv
module sim_evt_formatter;
    localparam int CLK_NS = 10;
    localparam logic [31:0] MARK = 32'hFEED_FACE;

    logic        clk = 0, rst = 1;
    logic        burst_start = 0, burst_end = 0, trig = 0;
    logic [31:0] trig_time = 0;
    logic [7:0]  err_in = 0;
    logic        in_valid = 0, in_last = 0;
    logic [31:0] in_data = 0;
    logic        in_ready, out_valid, out_ready = 1;
    logic [31:0] out_data;

    evt_formatter u0 (
        .clk(clk), .rst(rst), .burst_start(burst_start), .burst_end(burst_end),
        .trig(trig), .trig_time(trig_time), .err_in(err_in),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    always #(CLK_NS/2) clk = ~clk;

    int nchk = 0, nfail = 0;
    int cyc = 0;
    logic [31:0] cap [0:255];
    int          cap_edge [0:255];
    int          ncap = 0;
    int          stall_seen = 0, stall_bad = 0;
    logic        hold_pend = 0;
    logic [31:0] held = 0;
    int          be_edge = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && ncap < 256) begin
            cap[ncap]      = out_data;
            cap_edge[ncap] = cyc + 1;
            ncap++;
        end
        if (hold_pend) begin
            stall_seen++;
            if (!(out_valid && out_data == held)) stall_bad++;
        end
        hold_pend = !rst && out_valid && !out_ready;
        held      = out_data;
    end

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) burst_start = 1;
        @(negedge clk) burst_start = 0;
    endtask

    task automatic pulse_end();
        @(negedge clk) burst_end = 1;
        @(negedge clk) burst_end = 0;
    endtask

    task automatic send_payload(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            in_valid = 1;
            in_data  = base + i;
            in_last  = (i == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 0;
        in_last  = 0;
    endtask

    task automatic run_event(logic [31:0] ts, int n, logic [31:0] base,
                             logic [7:0] e1, logic [7:0] e2, bit extra);
        @(negedge clk) begin trig = 1; trig_time = ts; end
        @(negedge clk) begin trig = 0; err_in = e1; end
        fork
            send_payload(n, base);
            begin
                @(negedge clk) err_in = e2;
                @(negedge clk) err_in = 0;
                if (extra) begin
                    trig = 1;
                    @(negedge clk) trig = 0;
                end
            end
        join
        repeat (6) @(negedge clk);
    endtask

    task automatic chk_event(int at, int evt, int bst, logic [31:0] ts, int n,
                             logic [31:0] base, logic [7:0] err);
        check_eq("R2 header word", cap[at], {evt[15:0], bst[7:0], 8'h00});
        check_eq("R2 timestamp", cap[at+1], ts);
        for (int i = 0; i < n; i++)
            check_eq("R3 payload", cap[at+2+i], base + i);
        check_eq("R4 marker", cap[at+2+n], MARK);
        check_eq("R4/R7 length+errors", cap[at+3+n], {err, 24'(n)});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_eq("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
        check_eq("R1 in_ready after reset", {31'b0, in_ready}, 32'd0);
    endtask

    task automatic t_trig_outside();
        ncap = 0;
        @(negedge clk) begin trig = 1; trig_time = 32'hDEAD0001; end
        @(negedge clk) trig = 0;
        repeat (6) @(negedge clk);
        check_eq("R6 trigger outside burst ignored", ncap, 0);
        check_eq("R1 idle out_valid", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_burst_one();
        ncap = 0;
        pulse_start();
        run_event(32'h1234_5678, 3, 32'h100, 8'h00, 8'h00, 0);
        run_event(32'h0BAD_F00D, 2, 32'h200, 8'h01, 8'h10, 1);
        run_event(32'h0000_0042, 1, 32'h300, 8'h00, 8'h00, 0);
        pulse_end();
        repeat (8) @(negedge clk);
        check_eq("R6 busy trigger ignored (word count)", ncap, 20);
        chk_event(0, 0, 1, 32'h1234_5678, 3, 32'h100, 8'h00);   // R5 first burst = 1
        chk_event(7, 1, 1, 32'h0BAD_F00D, 2, 32'h200, 8'h11);   // R7 OR of 0x01,0x10
        chk_event(13, 2, 1, 32'h0000_0042, 1, 32'h300, 8'h00);  // R7 cleared
        check_eq("R8 total words", cap[18], 32'd18);
        check_eq("R9 readout time idle end", cap[19], 32'd0);
    endtask

    task automatic t_burst_two();
        ncap = 0;
        stall_seen = 0;
        stall_bad = 0;
        pulse_start();
        repeat (2) @(negedge clk);
        @(negedge clk) begin trig = 1; trig_time = 32'hCAFE_0002; end
        @(negedge clk) trig = 0;
        fork
            send_payload(6, 32'h400);
            begin
                repeat (3) @(negedge clk);
                burst_end = 1;
                be_edge = cyc + 1;
                @(negedge clk) burst_end = 0;
            end
            begin
                for (int i = 0; i < 24; i++) begin
                    @(posedge clk);
                    #1 out_ready = (i % 3 != 1);
                end
                @(posedge clk);
                #1 out_ready = 1;
            end
        join
        repeat (12) @(negedge clk);
        check_eq("R10 no drop/dup word count", ncap, 12);
        chk_event(0, 0, 2, 32'hCAFE_0002, 6, 32'h400, 8'h00);   // R5 restart at 0
        check_eq("R8 total words", cap[10], 32'd10);
        check_eq("R9 readout time", cap[11], 32'(cap_edge[9] - be_edge));
        check_eq("R10 stalls exercised", {31'b0, stall_seen > 0}, 32'd1);
        check_eq("R10 word held while stalled", stall_bad, 0);
    endtask

    initial begin
        t_reset();
        t_trig_outside();
        t_burst_one();
        t_burst_two();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        nchk++;
        nfail++;
        $display("FAIL R10 watchdog act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule